// File: doc/BRIEF.md
# Clock Output Park and Shutdown Controller

This block sits beside a reference clock and decides, for each of a small set of buffered clock outputs, whether it toggles or is parked. Three kinds of control pin drive that decision: a power-down request that stops everything and turns the oscillator off, a stop request that parks a fixed subset of outputs, and two output-enable pins that each govern their own group of outputs. The active level of these pins is not fixed. It is set by a strap input that is captured once, on the first clock edge after reset is released.

Every control pin passes through a two-flop synchronizer before it acts. Each output's gate register changes only on a rising reference edge, and the output is the OR of the reference clock with the inverted gate. A stopped output therefore stays high, and neither a high nor a low phase is ever cut short. On power-down all gates close first and the oscillator enable drops one cycle later. On wake-up the oscillator enable rises first, and the gates reopen only after a fixed settling count. A parked output is either driven high or released (output enable low), as set by a global float bit and a per-output disable bit in a small register file. The register file also holds a read-only identity byte.

Top module: `clk_park_ctrl`

## Requirements
- R1: The strap is captured on the first rising edge after reset is released. Later changes on the strap input have no effect on pin polarity until the next reset.
- R2: With the strap captured as 0, the power-down and stop pins are asserted when low and the two enable pins are active when high. With the strap captured as 1, all of these levels are inverted.
- R3: A level change on any control pin affects the outputs at the third rising edge after it is applied, and not before.
- R4: Power-down closes every output gate on one edge. The oscillator enable `vco_en` falls on the next edge, and it is never low while any gate is open.
- R5: A parked output i has `clk_oe[i]`=0 when the float bit or its own disable bit is set. Otherwise it is driven high with `clk_oe[i]`=1. A running output always has `clk_oe[i]`=1.
- R6: Gates change only at rising edges. A running output is low throughout the low phase of the reference clock, and a parked output is high throughout it.
- R7: On release of power-down, `vco_en` rises at the third edge after the pin change. Gates stay closed for WAKE_CYCLES further edges and open on the edge after that (edge 3+WAKE_CYCLES+1). A new power-down request during the wait sends the block back to shutdown.
- R8: The stop pin parks only outputs 1 and 2. Enable pin A governs outputs 0 and 1, and enable pin B governs outputs 2 and 3.
- R9: The register map is as follows. Address 0 has the float bit at bit 0. Address 1 has the per-output disable bits at bits 3:0. Address 2 is the identity byte, 0x08 (revision 0 in the upper nibble, vendor 8 in the lower), and is read-only. Address 3 reads 0. Writable registers reset to 0, and their reserved bits read 0 and ignore writes.
- R10: During reset and for the first startup edges, `vco_en` is 0 and all outputs are parked high with `clk_oe`=1. The block then runs the wake sequence of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_inv | input | 1 | Polarity strap, captured once after reset |
| pd_pin | input | 1 | Asynchronous power-down request |
| stop_pin | input | 1 | Stop request for the stoppable subset |
| oe_a_pin | input | 1 | Enable for output group A |
| oe_b_pin | input | 1 | Enable for output group B |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| clk_out | output | NUM_OUT | Gated clock outputs |
| clk_oe | output | NUM_OUT | Output drive enables (0 = released) |
| vco_en | output | 1 | Oscillator enable |

## Verification
A control pin change acts at the third rising edge, because the two synchronizer flops come before the gate register. A register write acts on outputs one edge after the write edge. `vco_en` follows the gates by one edge on shutdown and leads them by WAKE_CYCLES+1 edges on wake-up. The bench's behavioural model advances once per rising edge with these same delays. It is compared at mid low phase, so each expected value is checked in the exact cycle it becomes due. Directed checks confirm the edge counts around each stop, shutdown and wake-up, sampling one cycle before and in the cycle of the change.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAKE = 2'd1,
    ST_RUN  = 2'd2,
    ST_PARK = 2'd3
  } park_state_e;

  // Asserted meaning of a pin level; flip=1 makes the pin active-low.
  function automatic logic pin_asserted(input logic level, input logic flip);
    return level ^ flip;
  endfunction

  // Parked output is released when either the global or its own bit is set.
  function automatic logic park_floats(input logic float_all, input logic dis_bit);
    return float_all | dis_bit;
  endfunction

endpackage

// File: rtl/clk_park_sync.sv
module clk_park_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clk_park_regs.sv
module clk_park_regs #(
  parameter int         NUM_OUT = 4,
  parameter logic [3:0] REV_ID  = 4'h0,
  parameter logic [3:0] VEND_ID = 4'h8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               float_all,
  output logic [NUM_OUT-1:0] dis_bits
);
  localparam logic [7:0] CTRL_MASK = 8'h01;
  localparam logic [7:0] DIS_MASK  = 8'((1 << NUM_OUT) - 1);
  localparam logic [7:0] ID_BYTE   = {REV_ID, VEND_ID};

  logic [7:0] ctrl_q, dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dis_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) ctrl_q <= reg_wdata & CTRL_MASK;
      if (reg_addr == 2'd1) dis_q  <= reg_wdata & DIS_MASK;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl_q;
      2'd1:    reg_rdata = dis_q;
      2'd2:    reg_rdata = ID_BYTE;
      default: reg_rdata = '0;
    endcase
  end

  assign float_all = ctrl_q[0];
  assign dis_bits  = dis_q[NUM_OUT-1:0];

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[7:1] == 7'd0));
  assert_id_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata == 8'h08 || ID_BYTE != 8'h08));
endmodule

// File: rtl/clk_park_seq.sv
module clk_park_seq
  import clk_park_pkg::*;
#(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic pd_act,
  output logic gate_ok,
  output logic vco_en
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);

  park_state_e    state_q, state_n;
  logic [CW-1:0]  cnt_q;
  logic           wake_last;

  assign wake_last = (cnt_q == CW'(WAKE_CYCLES - 1));

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_RUN:  if (pd_act) state_n = ST_PARK;
      ST_PARK: state_n = ST_OFF;
      ST_OFF:  if (!pd_act) state_n = ST_WAKE;
      ST_WAKE: if (pd_act) state_n = ST_PARK;
               else if (wake_last) state_n = ST_RUN;
      default: state_n = ST_OFF;
    endcase
  end

  assign gate_ok = ready && (state_q == ST_RUN) && !pd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      vco_en  <= 1'b0;
    end else if (ready) begin
      state_q <= state_n;
      vco_en  <= (state_n != ST_OFF);
      if (state_q == ST_WAKE) cnt_q <= cnt_q + 1'b1;
      else                    cnt_q <= '0;
    end
  end

  assert_vco_rise_from_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_en) |-> ($past(state_q) == ST_OFF));
  assert_run_after_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_WAKE) |-> $past(wake_last));
endmodule

// File: rtl/clk_park_gate.sv
module clk_park_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic open_n,
  input  logic float_sel,
  output logic gate_en,
  output logic clk_out,
  output logic clk_oe
);
  logic en_q, oe_q;

  // Gate changes at rising edges only; OR form parks the output high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      oe_q <= 1'b1;
    end else begin
      en_q <= open_n;
      oe_q <= open_n | ~float_sel;
    end
  end

  assign gate_en = en_q;
  assign clk_out = clk | ~en_q;
  assign clk_oe  = oe_q;

  assert_release_only_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !en_q);
endmodule

// File: rtl/clk_park_ctrl.sv
module clk_park_ctrl
  import clk_park_pkg::*;
#(
  parameter int                  NUM_OUT     = 4,
  parameter int                  WAKE_CYCLES = 8,
  parameter logic [NUM_OUT-1:0]  STOP_MASK   = 4'b0110,
  parameter logic [NUM_OUT-1:0]  GRP_A_MASK  = 4'b0011,
  parameter logic [NUM_OUT-1:0]  GRP_B_MASK  = 4'b1100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_inv,
  input  logic               pd_pin,
  input  logic               stop_pin,
  input  logic               oe_a_pin,
  input  logic               oe_b_pin,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_oe,
  output logic               vco_en
);
  localparam int NPIN = 4;

  logic [1:0]         boot_q;
  logic               strap_q;
  logic               ready;
  logic [NPIN-1:0]    pin_s;
  logic               pd_act, stop_act, grp_a_on, grp_b_on;
  logic               gate_ok, float_all;
  logic [NUM_OUT-1:0] dis_bits, want, gate_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= '0;
      strap_q <= 1'b0;
    end else begin
      if (boot_q == 2'd0) strap_q <= strap_inv;
      if (boot_q != 2'd3) boot_q <= boot_q + 2'd1;
    end
  end
  assign ready = (boot_q == 2'd3);

  clk_park_sync #(.WIDTH(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({oe_b_pin, oe_a_pin, stop_pin, pd_pin}),
    .q(pin_s)
  );

  assign pd_act   = pin_asserted(pin_s[0], ~strap_q);
  assign stop_act = pin_asserted(pin_s[1], ~strap_q);
  assign grp_a_on = pin_asserted(pin_s[2], strap_q);
  assign grp_b_on = pin_asserted(pin_s[3], strap_q);

  clk_park_regs #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .float_all(float_all), .dis_bits(dis_bits)
  );

  clk_park_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .ready(ready), .pd_act(pd_act),
    .gate_ok(gate_ok), .vco_en(vco_en)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign want[i] = gate_ok
                   && !(stop_act && STOP_MASK[i])
                   && !(!grp_a_on && GRP_A_MASK[i])
                   && !(!grp_b_on && GRP_B_MASK[i])
                   && !dis_bits[i];
    clk_park_gate u_gate (
      .clk(clk), .rst_n(rst_n), .open_n(want[i]),
      .float_sel(park_floats(float_all, dis_bits[i])),
      .gate_en(gate_en[i]), .clk_out(clk_out[i]), .clk_oe(clk_oe[i])
    );
  end

  assert_vco_off_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_en |-> (gate_en == '0));
  assert_park_before_vco_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_en) |-> ($past(gate_en) == '0));
  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> $stable(strap_q));
  assert_open_needs_vco_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_en & ~$past(gate_en)) != '0) |-> ($past(vco_en) && vco_en));
endmodule

// File: tb/clk_park_ctrl_tb.sv
module clk_park_ctrl_tb;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_inv = 1'b0, pd_pin = 1'b1, stop_pin = 1'b1, oe_a_pin = 1'b1, oe_b_pin = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [N-1:0] clk_out, clk_oe;
  logic vco_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_park_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .strap_inv(strap_inv), .pd_pin(pd_pin),
    .stop_pin(stop_pin), .oe_a_pin(oe_a_pin), .oe_b_pin(oe_b_pin),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clk_out(clk_out), .clk_oe(clk_oe), .vco_en(vco_en)
  );

  // Behavioural reference: 0 off, 1 waiting, 2 running, 3 parking
  int m_boot, m_strap, m_state, m_cnt, m_vco, m_mode, m_dis;
  int m_s1 [4];
  int m_s2 [4];
  int m_en [N];
  int m_oe [N];

  task automatic m_reset();
    m_boot = 0; m_strap = 0; m_state = 0; m_cnt = 0; m_vco = 0; m_mode = 0; m_dis = 0;
    for (int k = 0; k < 4; k++) begin m_s1[k] = 0; m_s2[k] = 0; end
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_oe[i] = 1; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int pd, st, ga, gb, rdy, nxt;
      pd = m_strap ? m_s2[0] : !m_s2[0];
      st = m_strap ? m_s2[1] : !m_s2[1];
      ga = m_strap ? !m_s2[2] : m_s2[2];
      gb = m_strap ? !m_s2[3] : m_s2[3];
      rdy = (m_boot == 3);
      for (int i = 0; i < N; i++) begin
        int w;
        w = 1;
        if (st && (i == 1 || i == 2)) w = 0;
        if (!ga && i < 2) w = 0;
        if (!gb && i >= 2) w = 0;
        if ((m_dis >> i) & 1) w = 0;
        m_en[i] = (rdy && m_state == 2 && !pd) ? w : 0;
        m_oe[i] = m_en[i] || !(m_mode || ((m_dis >> i) & 1));
      end
      if (rdy) begin
        nxt = m_state;
        case (m_state)
          2: if (pd) nxt = 3;
          3: nxt = 0;
          0: if (!pd) nxt = 1;
          default: if (pd) nxt = 3; else if (m_cnt == W - 1) nxt = 2;
        endcase
        m_cnt = (m_state == 1) ? m_cnt + 1 : 0;
        m_state = nxt;
        m_vco = (nxt != 0);
      end
      if (m_boot == 0) m_strap = strap_inv;
      if (m_boot < 3) m_boot++;
      m_s2 = m_s1;
      m_s1[0] = pd_pin; m_s1[1] = stop_pin; m_s1[2] = oe_a_pin; m_s1[3] = oe_b_pin;
      if (reg_wr && reg_addr == 0) m_mode = reg_wdata[0];
      if (reg_wr && reg_addr == 1) m_dis = reg_wdata & 8'h0F;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    case (reg_addr)
      2'd0: return m_mode;
      2'd1: return m_dis;
      2'd2: return 8'h08;
      default: return 0;
    endcase
  endfunction

  // Per-cycle comparison at mid low phase
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++) begin
        check("R6 clk_out", clk_out[i], !m_en[i]);
        check("R5 clk_oe", clk_oe[i], m_oe[i]);
      end
      check("R4 vco_en", vco_en, m_vco);
      check("R9 reg_rdata", reg_rdata, exp_rdata());
    end
  end

  // Wait n rising edges, then stop at mid low phase (drive/sample point)
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #5;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Phase 1: strap 0
    step(3);
    rst_n = 1'b1;
    @(negedge clk); #5;
    check("R10 vco_en after reset", vco_en, 0);
    check("R10 outputs parked high", clk_out, 4'hF);
    check("R10 oe driven", clk_oe, 4'hF);
    reg_addr = 2'd2; #1;
    check("R9 id byte", reg_rdata, 8'h08);
    step(25);
    check("R10 running after wake", clk_out, 4'h0);

    // R1: strap change after capture ignored
    strap_inv = 1'b1;
    step(10);
    check("R1 strap ignored vco", vco_en, 1);
    check("R1 strap ignored outputs", clk_out, 4'h0);

    // R3/R8: stop parks outputs 1,2 on the third edge
    stop_pin = 1'b0;
    step(2);
    check("R3 stop not yet", clk_out, 4'h0);
    step(1);
    check("R3 stop at third edge", clk_out, 4'b0110);
    check("R8 stop subset oe", clk_oe, 4'hF);
    stop_pin = 1'b1;
    step(5);

    // R8: enable group A
    oe_a_pin = 1'b0;
    step(4);
    check("R8 group A parked", clk_out, 4'b0011);
    oe_a_pin = 1'b1;
    step(4);
    check("R2 group A active high", clk_out, 4'h0);

    // R5: float bit releases group B when parked
    wr(2'd0, 8'hFF);
    reg_addr = 2'd0; #1;
    check("R9 reserved ctrl bits", reg_rdata, 8'h01);
    oe_b_pin = 1'b0;
    step(4);
    check("R5 floated group B", clk_oe, 4'b0011);
    oe_b_pin = 1'b1;
    wr(2'd0, 8'h00);
    step(4);
    wr(2'd1, 8'hFF);
    reg_addr = 2'd1; #1;
    check("R9 reserved disable bits", reg_rdata, 8'h0F);
    wr(2'd2, 8'h55);
    reg_addr = 2'd2; #1;
    check("R9 id read-only", reg_rdata, 8'h08);
    wr(2'd1, 8'h01);
    step(1);
    check("R5 disabled output released", clk_oe, 4'b1110);
    check("R5 disabled output parked", clk_out, 4'b0001);
    wr(2'd1, 8'h00);
    step(3);

    // R4: power-down
    pd_pin = 1'b0;
    step(3);
    check("R4 gates closed", clk_out, 4'hF);
    check("R4 vco still on", vco_en, 1);
    step(1);
    check("R4 vco off next edge", vco_en, 0);
    step(4);

    // R7: wake
    pd_pin = 1'b1;
    step(2);
    check("R7 vco not yet", vco_en, 0);
    step(1);
    check("R7 vco at third edge", vco_en, 1);
    step(W);
    check("R7 still parked", clk_out, 4'hF);
    step(1);
    check("R7 outputs open", clk_out, 4'h0);

    // R7: re-request during wait
    pd_pin = 1'b0; step(6);
    pd_pin = 1'b1; step(5);
    pd_pin = 1'b0; step(6);
    check("R7 abort wait vco off", vco_en, 0);
    pd_pin = 1'b1; step(20);

    // Phase 2: strap 1, inverted pins
    rst_n = 1'b0;
    strap_inv = 1'b1; pd_pin = 1'b0; stop_pin = 1'b0; oe_a_pin = 1'b0; oe_b_pin = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(25);
    check("R2 inverted running", clk_out, 4'h0);
    strap_inv = 1'b0;
    stop_pin = 1'b1;
    step(4);
    check("R2 inverted stop", clk_out, 4'b0110);
    stop_pin = 1'b0;
    oe_b_pin = 1'b1;
    step(4);
    check("R2 inverted group B", clk_out, 4'b1100);
    oe_b_pin = 1'b0;
    pd_pin = 1'b1;
    step(6);
    check("R2 inverted power-down", vco_en, 0);
    pd_pin = 1'b0;
    step(20);
    check("R1 strap held after capture", clk_out, 4'h0);
    finish_run();
  end
endmodule